// File: doc/BRIEF.md
# Nibble-Command Register Access Decoder

This block sits behind a host byte channel and turns a stream of command bytes into reads and writes on an internal register space. The space has an 8-bit address and 8-bit data. Every command byte has an opcode in its upper four bits and a 4-bit payload in its lower four bits. A full address or a full data byte is therefore built from two command bytes, one nibble at a time. Read results leave through a separate byte stream that uses a valid/ready handshake.

The register space holds three kinds of location:
- a small array of general registers;
- a scratch register, which a host writes with alternating bit patterns and reads back to check the link;
- a read-only identification register that always returns a fixed constant.

Reads can advance the address automatically. The increment touches only the low address nibble, so an incrementing burst stays within its 16-register group and wraps around inside it. Writes never move the address. A host can therefore send several data pairs in a row to the same register.

Top module: `nibcmd_regdec`

## Requirements
- R1: Opcode 0x0 (command bits 7:4) loads its payload into address bits 3:0. Opcode 0x1 loads its payload into address bits 7:4. The other address nibble keeps its value.
- R2: Opcode 0x2 latches its payload as the pending low data nibble. Opcode 0x3 writes the byte {payload, pending low nibble} to the register at the current address. The written value is visible to the next read.
- R3: Opcode 0x4 places the byte at the current address on the read stream, one cycle after the command is accepted. The address is left unchanged.
- R4: Opcode 0x5 behaves like 0x4 and then adds one to address bits 3:0 only. The low nibble wraps from 0xF to 0x0, and address bits 7:4 keep their value.
- R5: Opcodes 0x2 and 0x3 never change the address. Successive data pairs after one address setup all go to that same register, and the last pair written is the value kept.
- R6: The scratch register at address 0x0F reads back exactly the last byte written to it, including 0x55 and 0xAA.
- R7: The identification register at address 0x00 always reads 0xA5. Writes to it are discarded.
- R8: Opcodes 0x6 to 0xF are accepted but ignored. They change neither the address nor the pending nibble, and they produce no read byte.
- R9: While a read byte is waiting (rd_valid high), cmd_ready is low and no command is taken. While rd_ready is low, rd_valid stays high and rd_data stays unchanged.
- R10: A synchronous active-high reset clears the address, the pending low nibble, the general registers and the scratch register to zero. It also drops rd_valid.
- R11: Addresses outside 0x00, 0x0F and the general array 0x10 to 0x1F read as 0x00. Writes to them are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command byte present |
| cmd_byte | input | 8 | Command: opcode in bits 7:4, payload in bits 3:0 |
| cmd_ready | output | 1 | Command byte is taken on this edge if valid |
| rd_valid | output | 1 | Read byte present |
| rd_data | output | 8 | Read byte |
| rd_ready | input | 1 | Consumer takes the read byte on this edge |

## Verification
The assertions assume that the host holds cmd_byte steady while cmd_valid is high and cmd_ready is low. They also assume that rd_ready is a plain level, with no dependence on cmd_valid.

The bench drives every input at the falling edge. It offers each command only while it sees cmd_ready high, and it withdraws cmd_valid as soon as the byte has been taken. The one deliberate exception is the stall test. There the bench holds a command steady against a low cmd_ready, which exercises the stall assumption directly, and it keeps rd_ready as a level that it changes only between clock edges.

// File: rtl/nibcmd_pkg.sv
package nibcmd_pkg;

  typedef enum logic [3:0] {
    OP_ADDR_LO  = 4'h0,
    OP_ADDR_HI  = 4'h1,
    OP_DATA_LO  = 4'h2,
    OP_DATA_WR  = 4'h3,
    OP_READ     = 4'h4,
    OP_READ_INC = 4'h5
  } op_e;

  typedef struct packed {
    logic       set_lo;
    logic       set_hi;
    logic       hold_nib;
    logic       commit;
    logic       read;
    logic       step;
    logic [3:0] nib;
  } dec_t;

  // Address after an incrementing read: only the low nibble moves.
  function automatic logic [7:0] step_in_group(input logic [7:0] a);
    logic [3:0] lo;
    lo = a[3:0] + 4'd1;
    return {a[7:4], lo};
  endfunction

  function automatic logic [7:0] join_nib(input logic [3:0] hi, input logic [3:0] lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/nibcmd_decode.sv
module nibcmd_decode
  import nibcmd_pkg::*;
(
  input  logic       fire,
  input  logic [7:0] cmd,
  output dec_t       dec
);
  always_comb begin
    dec     = '0;
    dec.nib = cmd[3:0];
    if (fire) begin
      unique case (cmd[7:4])
        OP_ADDR_LO:  dec.set_lo   = 1'b1;
        OP_ADDR_HI:  dec.set_hi   = 1'b1;
        OP_DATA_LO:  dec.hold_nib = 1'b1;
        OP_DATA_WR:  dec.commit   = 1'b1;
        OP_READ:     dec.read     = 1'b1;
        OP_READ_INC: begin
          dec.read = 1'b1;
          dec.step = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nibcmd_regfile.sv
module nibcmd_regfile #(
  parameter int unsigned      FILE_BASE  = 16,
  parameter int unsigned      FILE_DEPTH = 16,
  parameter logic [7:0]       SCR_ADDR   = 8'h0F,
  parameter logic [7:0]       ID_ADDR    = 8'h00,
  parameter logic [7:0]       ID_VALUE   = 8'hA5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data
);
  localparam int unsigned IDX_W = (FILE_DEPTH > 1) ? $clog2(FILE_DEPTH) : 1;
  localparam int unsigned LIMIT = FILE_BASE + FILE_DEPTH;

  logic [7:0] cells [FILE_DEPTH];
  logic [7:0] scratch_q;

  function automatic logic in_file(input logic [7:0] a);
    return (int'(a) >= int'(FILE_BASE)) && (int'(a) < int'(LIMIT));
  endfunction

  function automatic logic [IDX_W-1:0] to_idx(input logic [7:0] a);
    int unsigned off;
    off = int'(a) - FILE_BASE;
    return off[IDX_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) scratch_q <= '0;
    else if (wr_en && wr_addr == SCR_ADDR) scratch_q <= wr_data;
  end

  for (genvar g = 0; g < FILE_DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) cells[g] <= '0;
      else if (wr_en && in_file(wr_addr) && to_idx(wr_addr) == IDX_W'(g))
        cells[g] <= wr_data;
    end
  end

  always_comb begin
    if (rd_addr == ID_ADDR)       rd_data = ID_VALUE;
    else if (rd_addr == SCR_ADDR) rd_data = scratch_q;
    else if (in_file(rd_addr))    rd_data = cells[to_idx(rd_addr)];
    else                          rd_data = 8'h00;
  end
endmodule

// File: rtl/nibcmd_rdout.sv
module nibcmd_rdout (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_data,
  input  logic       rd_ready,
  output logic       rd_valid,
  output logic [7:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (load) begin
      rd_valid <= 1'b1;
      rd_data  <= load_data;
    end else if (rd_valid && rd_ready) begin
      rd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/nibcmd_regdec.sv
module nibcmd_regdec
  import nibcmd_pkg::*;
#(
  parameter int unsigned FILE_BASE  = 16,
  parameter int unsigned FILE_DEPTH = 16,
  parameter logic [7:0]  SCR_ADDR   = 8'h0F,
  parameter logic [7:0]  ID_ADDR    = 8'h00,
  parameter logic [7:0]  ID_VALUE   = 8'hA5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output logic       cmd_ready,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  input  logic       rd_ready
);
  logic       cmd_fire;
  dec_t       dec;
  logic [7:0] cur_addr;
  logic [3:0] nib_lo;
  logic [7:0] file_rd;
  logic       wr_strobe;
  logic [7:0] wr_byte;

  assign cmd_ready = !rd_valid;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign wr_strobe = dec.commit;
  assign wr_byte   = join_nib(dec.nib, nib_lo);

  nibcmd_decode u_dec (
    .fire (cmd_fire),
    .cmd  (cmd_byte),
    .dec  (dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      nib_lo   <= '0;
    end else begin
      if (dec.set_lo)   cur_addr[3:0] <= dec.nib;
      if (dec.set_hi)   cur_addr[7:4] <= dec.nib;
      if (dec.step)     cur_addr      <= step_in_group(cur_addr);
      if (dec.hold_nib) nib_lo        <= dec.nib;
    end
  end

  nibcmd_regfile #(
    .FILE_BASE  (FILE_BASE),
    .FILE_DEPTH (FILE_DEPTH),
    .SCR_ADDR   (SCR_ADDR),
    .ID_ADDR    (ID_ADDR),
    .ID_VALUE   (ID_VALUE)
  ) u_file (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_strobe),
    .wr_addr (cur_addr),
    .wr_data (wr_byte),
    .rd_addr (cur_addr),
    .rd_data (file_rd)
  );

  nibcmd_rdout u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (dec.read),
    .load_data (file_rd),
    .rd_ready  (rd_ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/nibcmd_regdec_chk.sv
module nibcmd_regdec_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_fire,
  input logic [7:0] cmd_byte,
  input logic       cmd_ready,
  input logic [7:0] cur_addr,
  input logic [3:0] nib_lo,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data
);
  a_r1_addr_hi: assert property (@(posedge clk) disable iff (rst)
    cmd_fire && cmd_byte[7:4] == 4'h1 |=>
      cur_addr == {$past(cmd_byte[3:0]), $past(cur_addr[3:0])});

  a_r2_nib_latch: assert property (@(posedge clk) disable iff (rst)
    cmd_fire && cmd_byte[7:4] == 4'h2 |=> nib_lo == $past(cmd_byte[3:0]));

  a_r3_read_out: assert property (@(posedge clk) disable iff (rst)
    cmd_fire && cmd_byte[7:4] == 4'h4 |=> rd_valid && $stable(cur_addr));

  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    cmd_fire && cmd_byte[7:4] == 4'h5 |=>
      cur_addr[7:4] == $past(cur_addr[7:4]) &&
      cur_addr[3:0] == 4'($past(cur_addr[3:0]) + 4'd1));

  a_r5_write_keeps_addr: assert property (@(posedge clk) disable iff (rst)
    cmd_fire && (cmd_byte[7:4] == 4'h2 || cmd_byte[7:4] == 4'h3) |=> $stable(cur_addr));

  a_r8_ignore: assert property (@(posedge clk) disable iff (rst)
    cmd_fire && cmd_byte[7:4] > 4'h5 |=>
      $stable(cur_addr) && $stable(nib_lo) && !rd_valid);

  a_r9_stall: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !cmd_ready);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
endmodule

bind nibcmd_regdec nibcmd_regdec_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_fire  (cmd_fire),
  .cmd_byte  (cmd_byte),
  .cmd_ready (cmd_ready),
  .cur_addr  (cur_addr),
  .nib_lo    (nib_lo),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data)
);

// File: tb/nibcmd_regdec_tb.sv
module nibcmd_regdec_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       cmd_ready;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       rd_ready = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  nibcmd_regdec u_dut (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .cmd_ready (cmd_ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_ready  (rd_ready)
  );

  // {check, command, expected read byte}
  localparam int NV = 40;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'h0F, 8'h00}, {1'b0, 8'h10, 8'h00},                        // addr 0x0F
    {1'b0, 8'h25, 8'h00}, {1'b0, 8'h35, 8'h00}, {1'b1, 8'h40, 8'h55},  // R6
    {1'b0, 8'h2A, 8'h00}, {1'b0, 8'h3A, 8'h00}, {1'b1, 8'h40, 8'hAA},  // R6
    {1'b0, 8'h00, 8'h00}, {1'b1, 8'h40, 8'hA5},                        // R7
    {1'b0, 8'h21, 8'h00}, {1'b0, 8'h32, 8'h00}, {1'b1, 8'h40, 8'hA5},  // R7 discard
    {1'b0, 8'h0F, 8'h00}, {1'b1, 8'h50, 8'hAA}, {1'b1, 8'h40, 8'hA5},  // R4 wrap 0x0F->0x00
    {1'b0, 8'h11, 8'h00},                                              // R1 addr 0x10
    {1'b0, 8'h23, 8'h00}, {1'b0, 8'h34, 8'h00},                        // 0x43 @0x10
    {1'b0, 8'h01, 8'h00}, {1'b0, 8'h2C, 8'h00}, {1'b0, 8'h3B, 8'h00},  // 0xBC @0x11
    {1'b0, 8'h0E, 8'h00}, {1'b0, 8'h27, 8'h00}, {1'b0, 8'h36, 8'h00},  // 0x67 @0x1E
    {1'b0, 8'h29, 8'h00}, {1'b0, 8'h38, 8'h00},                        // R5 0x89 @0x1E
    {1'b0, 8'h0F, 8'h00}, {1'b0, 8'h2D, 8'h00}, {1'b0, 8'h3E, 8'h00},  // 0xED @0x1F
    {1'b0, 8'h0E, 8'h00}, {1'b1, 8'h50, 8'h89}, {1'b1, 8'h50, 8'hED},  // R5 R4
    {1'b1, 8'h50, 8'h43}, {1'b1, 8'h40, 8'hBC}, {1'b1, 8'h40, 8'hBC},  // R4 wrap, R3
    {1'b0, 8'h6F, 8'h00}, {1'b0, 8'hF3, 8'h00}, {1'b0, 8'h77, 8'h00},  // R8
    {1'b1, 8'h40, 8'hBC}                                               // R8 unchanged
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    cmd_byte  = b;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Issue a read; the byte is visible at the negedge after acceptance.
  task automatic read_chk(input logic [7:0] op, input logic [7:0] exp, input string req);
    send(op);
    check({req, " valid"}, {7'd0, rd_valid}, 8'h01);
    check(req, rd_data, exp);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state at the ports
    check("R10 rd_valid", {7'd0, rd_valid}, 8'h00);
    check("R10 cmd_ready", {7'd0, cmd_ready}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16]) read_chk(VEC[i][15:8], VEC[i][7:0], $sformatf("R3/R4/R5/R6/R7/R8 vec%0d", i));
      else            send(VEC[i][15:8]);
    end

    // R11: unmapped address 0x75
    send(8'h05); send(8'h17); send(8'h2F); send(8'h3F);
    read_chk(8'h40, 8'h00, "R11 unmapped");

    // R2: pending nibble survives other commands before commit
    send(8'h12); send(8'h06); send(8'h2B); send(8'h01); send(8'h3C);  // 0xCB @0x21? no: addr 0x21 unmapped
    send(8'h00); send(8'h13);                                          // addr 0x30
    send(8'h11); send(8'h02); send(8'h3D);                             // 0xDB @0x12
    read_chk(8'h40, 8'hDB, "R2 kept nibble");

    // R9: stall while the read byte waits
    @(negedge clk);
    rd_ready  = 1'b0;
    cmd_byte  = 8'h40;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_byte = 8'h0A;  // held against low cmd_ready
    repeat (3) begin
      @(negedge clk);
      check("R9 cmd_ready low", {7'd0, cmd_ready}, 8'h00);
      check("R9 held byte", rd_data, 8'hDB);
    end
    cmd_valid = 1'b0;
    rd_ready  = 1'b1;
    @(negedge clk);
    check("R9 released", {7'd0, rd_valid}, 8'h00);
    read_chk(8'h40, 8'hDB, "R9 stalled cmd not taken");

    // R10: reset clears address, pending nibble, storage
    send(8'h0F); send(8'h10); send(8'h27);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    read_chk(8'h40, 8'hA5, "R10 address cleared");
    send(8'h0F);
    read_chk(8'h40, 8'h00, "R10 scratch cleared");
    send(8'h00); send(8'h11); send(8'h39);
    read_chk(8'h40, 8'h90, "R10 nibble cleared");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule